// File: doc/BRIEF.md
# Centred Three-Phase Space-Vector PWM Timer

This block turns one sample of three signed phase references into switching signals for the three legs of a two-level inverter. Each reference is scaled into a time count. The three times are ranked, and one common offset is added to all of them. The result is the same centred switching pattern that a sector-based space-vector modulator would give, but no angle, sector or lookup table is needed. Each leg output comes from comparing a triangular carrier counter with that leg's switching point. The block also reports which phase holds the middle rank. A downstream stage can use that flag to pick a zero-vector state.

Samples arrive on a valid/ready stream with one entry of storage. `in_ready` is high when no sample is waiting, and a sample is taken on a clock edge where `in_valid` and `in_ready` are both high. After a sample is taken, `in_ready` stays low until the waiting sample moves into the switching registers. That move happens only at the end of a carrier period, so the upstream sees back-pressure of up to one carrier period. While `in_ready` is low, the reference inputs are ignored. When no new sample arrives, the last pattern repeats.

Top module: `svpwm_centre_gen`

## Requirements
- R1: Each reference r (two's complement, DW bits) is scaled to the time t = floor(r * PERIOD / 2^(DW-1)). A reference of 2^(DW-1) therefore stands for the full dc-link voltage.
- R2: `in_ready` is high exactly when no sample is waiting. The cycle after a transfer, `in_ready` is low. References presented while `in_ready` is low, or while `in_valid` is low, have no effect on the outputs.
- R3: A waiting sample takes effect only at the end of a carrier period. `in_ready` returns high in the first cycle of the next period, and that period carries the new pattern.
- R4: The carrier counter `carr_cnt` steps 0, 1, …, PERIOD-1 while `carr_up` = 1. It then steps PERIOD-1, …, 1, 0 while `carr_up` = 0, giving 2*PERIOD clock cycles per period. A period starts when `carr_cnt` = 0 and `carr_up` = 1.
- R5: Each leg output is high while `carr_cnt` is at or above its switching point PERIOD - on, where on is in 0..PERIOD. The leg is therefore high for 2*on cycles per period, starting at cycle PERIOD-on of the period and centred in it.
- R6: on = t + off for each phase, with off = floor(Tz/2) - tmin. All three legs are high together for 2*floor(Tz/2) cycles, and all three are low together for 2*(Tz - floor(Tz/2)) cycles.
- R7: The active duration is Ta = tmax - tmin, and the zero duration is Tz = PERIOD - Ta.
- R8: If tmax - tmin exceeds PERIOD, Ta is clamped to PERIOD and Tz is 0. Each on value is then clamped into 0..PERIOD.
- R9: Exactly one of `mid_a`, `mid_b`, `mid_c` is high. It marks the phase of middle rank when the times are ordered from high to low, with equal times ordered A before B before C. The flag is updated together with the leg pattern.
- R10: After reset the block behaves as if all references were zero. `in_ready` = 1, `mid_b` = 1, each leg is high for 2*floor(PERIOD/2) cycles, and the carrier starts at 0 counting up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample on ref_a/b/c is offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| ref_a | input | DW | Phase A reference, signed |
| ref_b | input | DW | Phase B reference, signed |
| ref_c | input | DW | Phase C reference, signed |
| leg_a | output | 1 | Phase A upper-switch command |
| leg_b | output | 1 | Phase B upper-switch command |
| leg_c | output | 1 | Phase C upper-switch command |
| mid_a | output | 1 | Phase A holds the middle rank |
| mid_b | output | 1 | Phase B holds the middle rank |
| mid_c | output | 1 | Phase C holds the middle rank |
| carr_cnt | output | clog2(PERIOD+1) | Carrier count |
| carr_up | output | 1 | Carrier is counting up |

## Verification
The hardest case to reach from the ports is a tie in rank that happens together with overmodulation. When both occur, the clamping and the A-before-B-before-C ordering interact, and a wrong tie-break moves the middle flag without changing any leg pattern. Directed samples build exact ties between scaled times. They also use references near full scale, so that the spread between phases passes PERIOD. Random samples mix full-range values, which often overmodulate, with half-range values, which never do. Each sample is also offered just after the previous one is taken, and garbage references are driven while `in_ready` is low. This exercises the back-pressure window.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  localparam int NPH = 3;

  // phase j is ranked ahead of phase i: larger time, or equal time and lower index
  function automatic logic ranks_ahead(input int tj, input int ti, input int j, input int i);
    return (tj > ti) || ((tj == ti) && (j < i));
  endfunction

  function automatic int clamp_to(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/svpwm_scale.sv
module svpwm_scale #(
  parameter int DW     = 16,
  parameter int PERIOD = 100,
  parameter int TW     = 10
) (
  input  logic signed [DW-1:0] ref_i,
  output logic signed [TW-1:0] t_o
);
  localparam int PW = DW + $clog2(PERIOD) + 2;
  localparam logic signed [PW-1:0] PER_S = PW'(PERIOD);

  logic signed [PW-1:0] prod;

  always_comb begin
    prod = PW'(ref_i) * PER_S;
    t_o  = TW'(prod >>> (DW - 1));
  end
endmodule

// File: rtl/svpwm_rank.sv
module svpwm_rank
  import svpwm_pkg::*;
#(
  parameter int TW = 10
) (
  input  logic signed [TW-1:0] t_i [3],
  output logic signed [TW-1:0] tmax_o,
  output logic signed [TW-1:0] tmin_o,
  output logic [2:0]           mid_o
);
  always_comb begin
    int rk;
    tmax_o = t_i[0];
    tmin_o = t_i[0];
    mid_o  = '0;
    for (int i = 0; i < NPH; i++) begin
      rk = 0;
      for (int j = 0; j < NPH; j++) begin
        if (j != i && ranks_ahead(int'(t_i[j]), int'(t_i[i]), j, i)) rk = rk + 1;
      end
      if (rk == 0) tmax_o = t_i[i];
      if (rk == 2) tmin_o = t_i[i];
      mid_o[i] = (rk == 1);
    end
  end
endmodule

// File: rtl/svpwm_ontime.sv
module svpwm_ontime
  import svpwm_pkg::*;
#(
  parameter int TW     = 10,
  parameter int CW     = 7,
  parameter int PERIOD = 100
) (
  input  logic signed [TW-1:0] t_i [3],
  input  logic signed [TW-1:0] tmax_i,
  input  logic signed [TW-1:0] tmin_i,
  output logic [CW-1:0]        on_o [3]
);
  always_comb begin
    int ta;
    int tz;
    int off;
    int s;
    ta = int'(tmax_i) - int'(tmin_i);
    if (ta > PERIOD) ta = PERIOD;
    tz  = PERIOD - ta;
    off = (tz >>> 1) - int'(tmin_i);
    for (int i = 0; i < NPH; i++) begin
      s       = int'(t_i[i]) + off;
      on_o[i] = CW'(clamp_to(s, PERIOD));
    end
  end
endmodule

// File: rtl/svpwm_carrier.sv
module svpwm_carrier #(
  parameter int PERIOD = 100,
  parameter int CW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o,
  output logic          up_o,
  output logic          zero_o
);
  localparam logic [CW-1:0] TOP = CW'(PERIOD - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      up_o  <= 1'b1;
    end else if (up_o) begin
      if (cnt_o == TOP) up_o <= 1'b0;
      else              cnt_o <= cnt_o + CW'(1);
    end else begin
      if (cnt_o == '0) up_o <= 1'b1;
      else             cnt_o <= cnt_o - CW'(1);
    end
  end

  assign zero_o = !up_o && (cnt_o == '0);

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= TOP);
  p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o && cnt_o != TOP) |=> (up_o && cnt_o == $past(cnt_o) + CW'(1)));
  p_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o && cnt_o == TOP) |=> (!up_o && cnt_o == TOP));
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |=> (up_o && cnt_o == '0));
endmodule

// File: rtl/svpwm_centre_gen.sv
module svpwm_centre_gen #(
  parameter int DW     = 16,
  parameter int PERIOD = 100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic signed [DW-1:0]         ref_a,
  input  logic signed [DW-1:0]         ref_b,
  input  logic signed [DW-1:0]         ref_c,
  output logic                         leg_a,
  output logic                         leg_b,
  output logic                         leg_c,
  output logic                         mid_a,
  output logic                         mid_b,
  output logic                         mid_c,
  output logic [$clog2(PERIOD+1)-1:0]  carr_cnt,
  output logic                         carr_up
);
  localparam int TW   = $clog2(PERIOD) + 3;
  localparam int CW   = $clog2(PERIOD + 1);
  localparam int HALF = PERIOD / 2;

  logic                 pend;
  logic                 accept;
  logic [2:0][DW-1:0]   ref_q;
  logic signed [TW-1:0] t_w [3];
  logic signed [TW-1:0] tmax_w;
  logic signed [TW-1:0] tmin_w;
  logic [2:0]           mid_w;
  logic [CW-1:0]        on_w [3];
  logic [2:0][CW-1:0]   cmp_q;
  logic [2:0]           mid_q;
  logic [2:0]           leg_w;
  logic [CW-1:0]        cnt;
  logic                 up;
  logic                 zero_pt;

  svpwm_carrier #(.PERIOD(PERIOD), .CW(CW)) u_carrier (
    .clk(clk), .rst_n(rst_n), .cnt_o(cnt), .up_o(up), .zero_o(zero_pt)
  );

  for (genvar g = 0; g < 3; g++) begin : g_phase
    svpwm_scale #(.DW(DW), .PERIOD(PERIOD), .TW(TW)) u_scale (
      .ref_i($signed(ref_q[g])), .t_o(t_w[g])
    );
    assign leg_w[g] = (cnt >= cmp_q[g]);
  end

  svpwm_rank #(.TW(TW)) u_rank (
    .t_i(t_w), .tmax_o(tmax_w), .tmin_o(tmin_w), .mid_o(mid_w)
  );

  svpwm_ontime #(.TW(TW), .CW(CW), .PERIOD(PERIOD)) u_ontime (
    .t_i(t_w), .tmax_i(tmax_w), .tmin_i(tmin_w), .on_o(on_w)
  );

  assign in_ready = !pend;
  assign accept   = in_valid && !pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      ref_q <= '0;
      for (int i = 0; i < 3; i++) cmp_q[i] <= CW'(PERIOD - HALF);
      mid_q <= 3'b010;
    end else if (accept) begin
      pend  <= 1'b1;
      ref_q <= {ref_c, ref_b, ref_a};
    end else if (zero_pt && pend) begin
      pend  <= 1'b0;
      for (int i = 0; i < 3; i++) cmp_q[i] <= CW'(PERIOD) - on_w[i];
      mid_q <= mid_w;
    end
  end

  assign {leg_c, leg_b, leg_a} = leg_w;
  assign {mid_c, mid_b, mid_a} = mid_q;
  assign carr_cnt = cnt;
  assign carr_up  = up;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_pt |=> ($stable(cmp_q) && $stable(mid_q)));
  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !zero_pt) |=> !in_ready);
  p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_mid_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mid_q) == 1);
  p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmax_w >= tmin_w);
  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (on_w[0] <= CW'(PERIOD)) && (on_w[1] <= CW'(PERIOD)) && (on_w[2] <= CW'(PERIOD)));
  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q[0] <= CW'(PERIOD)) && (cmp_q[1] <= CW'(PERIOD)) && (cmp_q[2] <= CW'(PERIOD)));
endmodule

// File: tb/sim_svpwm_centre_gen.sv
module sim_svpwm_centre_gen;
  localparam int CLK_P = 10;
  localparam int DW    = 16;
  localparam int PER   = 100;
  localparam int CWB   = $clog2(PER + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic leg_a, leg_b, leg_c, mid_a, mid_b, mid_c, carr_up;
  logic [CWB-1:0] carr_cnt;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  svpwm_centre_gen #(.DW(DW), .PERIOD(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .leg_a(leg_a), .leg_b(leg_b), .leg_c(leg_c),
    .mid_a(mid_a), .mid_b(mid_b), .mid_c(mid_c),
    .carr_cnt(carr_cnt), .carr_up(carr_up)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int scl(input int r);
    return (r * PER) >>> (DW - 1);
  endfunction

  task automatic expect_vals(input int ra, input int rb, input int rc,
                             output int on_e[3], output int mid_e, output int tz_e);
    int t[3];
    int tmax, tmin, ta, off, s;
    t[0] = scl(ra); t[1] = scl(rb); t[2] = scl(rc);
    tmax = 0; tmin = 0; mid_e = 0;
    for (int i = 0; i < 3; i++) begin
      int rk = 0;
      for (int j = 0; j < 3; j++)
        if (j != i && ((t[j] > t[i]) || (t[j] == t[i] && j < i))) rk++;
      if (rk == 0) tmax = t[i];
      if (rk == 1) mid_e = i;
      if (rk == 2) tmin = t[i];
    end
    ta = tmax - tmin;
    if (ta > PER) ta = PER;
    tz_e = PER - ta;
    off = tz_e / 2 - tmin;
    for (int i = 0; i < 3; i++) begin
      s = t[i] + off;
      on_e[i] = (s < 0) ? 0 : ((s > PER) ? PER : s);
    end
  endtask

  // called at the negedge that opens a period; returns at the next period start
  task automatic measure(input int on_e[3], input int mid_e, input int tz_e, input string tag);
    int hi[3];
    int first[3];
    int allh = 0;
    int alll = 0;
    logic [2:0] legs;
    for (int i = 0; i < 3; i++) begin hi[i] = 0; first[i] = -1; end
    chk({"R4 period start ", tag}, int'(carr_cnt == 0 && carr_up), 1);
    chk({"R9 mid flags ", tag}, int'({mid_c, mid_b, mid_a}), 1 << mid_e);
    for (int k = 0; k < 2 * PER; k++) begin
      legs = {leg_c, leg_b, leg_a};
      if (k == PER) chk({"R4 turn point ", tag}, int'(carr_cnt == PER - 1 && !carr_up), 1);
      for (int i = 0; i < 3; i++)
        if (legs[i]) begin
          hi[i]++;
          if (first[i] < 0) first[i] = k;
        end
      if (legs == 3'b111) allh++;
      if (legs == 3'b000) alll++;
      @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      chk($sformatf("R5 high cycles leg%0d %s", i, tag), hi[i], 2 * on_e[i]);
      chk($sformatf("R5 first high leg%0d %s", i, tag), first[i],
          (on_e[i] > 0) ? PER - on_e[i] : -1);
    end
    chk({"R6 all high ", tag}, allh, 2 * (tz_e / 2));
    chk({"R6 all low ", tag}, alll, 2 * (tz_e - tz_e / 2));
  endtask

  task automatic run_sample(input int ra, input int rb, input int rc, input string tag);
    int on_e[3];
    int mid_e, tz_e;
    expect_vals(ra, rb, rc, on_e, mid_e, tz_e);
    in_valid = 1'b1;
    ref_a = DW'(ra); ref_b = DW'(rb); ref_c = DW'(rc);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    ref_a = DW'(-ra - 7); ref_b = DW'(32767); ref_c = DW'(-32768);
    chk({"R2 ready drops after take ", tag}, int'(in_ready), 0);
    while (!in_ready) begin
      ref_a = DW'(ref_a + 16'sd1234);
      @(negedge clk);
    end
    chk({"R3 update at period boundary ", tag}, int'(carr_cnt == 0 && carr_up), 1);
    measure(on_e, mid_e, tz_e, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL R3 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int on_e[3];
    int mid_e, tz_e;
    void'($urandom(32'd9127));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state behaves as all-zero references
    chk("R10 ready after reset", int'(in_ready), 1);
    chk("R10 mid_b after reset", int'({mid_c, mid_b, mid_a}), 3'b010);
    expect_vals(0, 0, 0, on_e, mid_e, tz_e);
    measure(on_e, mid_e, tz_e, "R10 reset pattern");

    run_sample(20000, 0, -20000, "R1 R7 spread");
    run_sample(-5000, 12000, 3000, "R1 mid C");
    run_sample(0, 0, 0, "R9 all tie");
    run_sample(8000, 8000, -9000, "R9 tie AB");
    run_sample(9000, -4000, 9000, "R9 tie AC");
    run_sample(9000, -4000, -4000, "R9 tie BC");
    run_sample(32767, -32768, 0, "R8 overmod");
    run_sample(-32768, 32767, 32767, "R8 overmod tie");
    run_sample(15000, -15000, 100, "R6 odd zero");
    run_sample(32767, 32767, 32767, "R7 common mode");

    for (int n = 0; n < 40; n++) begin
      int r[3];
      for (int i = 0; i < 3; i++) begin
        r[i] = int'($signed(16'($urandom)));
        if (n % 2 == 1) r[i] = r[i] >>> 1;
      end
      run_sample(r[0], r[1], r[2], $sformatf("R8 R9 random %0d", n));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule